// File: doc/BRIEF.md
# Comparator-Steered Adaptive PWM Engine

This block produces a fixed-period pulse-width waveform that drives the pass switch of a cell charger. A free-running divider turns the input clock into PWM ticks, and each period is `PERIOD` ticks long. The output stays high for the number of ticks held in a duty register. After reset that register holds `PERIOD-1`, so the switch is on for almost the whole period. An inverted copy of the waveform is provided for switches that turn on with a low gate.

A slow update divider counts whole periods and issues a one-clock strobe every `UPD_DIV` periods. When the charge sequencer enables updates, each strobe moves the duty register by one tick. A synchronized comparator bit sets the direction: the step is down while the cell voltage is above its limit and up while it is below. The duty register saturates at 1 tick and at `PERIOD-1` ticks. A new value reaches the output only at the next period boundary. A freeze input holds the update divider in reset and locks the duty cycle at its last value.

Top module: `pwm_servo_engine`

## Requirements
- R1: After reset the output is high for the first `PERIOD-1` ticks of each period and low for the last tick, and no strobe is issued during reset.
- R2: One period lasts exactly `PERIOD*TICK_DIV` clocks, and the true output goes from low to high at the start of every period.
- R3: While freeze is low, `upd_stb_o` is a single-clock pulse. It appears in the first clock of every `UPD_DIV`-th period, counted from reset release or from the last clock in which freeze was high.
- R4: On a strobe with updates enabled and freeze low, the duty register steps by one tick. It steps down when the synchronized direction bit is 1 and up when it is 0. The bit used is the value `dir_hi_i` held at the clock edge two edges before the update edge, after a two-flop synchronizer.
- R5: While `upd_en_i` is low, strobes still occur but the duty cycle does not change.
- R6: While `freeze_i` is high, no strobe is issued and the duty cycle does not change. The update divider restarts from zero.
- R7: `pwm_n_o` is always the logical inverse of `pwm_o`.
- R8: The duty register never goes below 1 tick or above `PERIOD-1` ticks. A step that would cross either bound leaves the value unchanged.
- R9: The high time of every period equals the duty value latched at that period's start, times `TICK_DIV` clocks. An update made during a period first shows in the following period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; PWM ticks are derived from it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| upd_en_i | input | 1 | Lets strobes change the duty cycle |
| dir_hi_i | input | 1 | Comparator bit, asynchronous; 1 means voltage above limit (step down) |
| freeze_i | input | 1 | Holds the update divider in reset and blocks duty changes |
| pwm_o | output | 1 | PWM waveform, high while the switch conducts |
| pwm_n_o | output | 1 | Inverted PWM for low-active gates |
| upd_stb_o | output | 1 | One-clock update strobe at a period start |

## Verification
The strobe rises in the same clock as the first tick of its period, one register after the wrap. The bench therefore compares it against its own period-boundary model at the same falling edge where it sees the rising edge of the PWM output. A duty step lands at the clock edge after the strobe and takes effect one full period later. The bench measures high time over whole periods, so a value is only checked in the period after the strobe that changed it. The direction value is taken from a history the bench keeps of what it drove two edges before the update edge. Enable and freeze are taken from the update edge itself.

// File: rtl/pwm_servo_pkg.sv
package pwm_servo_pkg;

    typedef enum logic {
        STEP_UP   = 1'b0,
        STEP_DOWN = 1'b1
    } step_dir_e;

    localparam int unsigned DEF_TICK_DIV = 4;
    localparam int unsigned DEF_PERIOD   = 62;
    localparam int unsigned DEF_UPD_DIV  = 256;

endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
    parameter int unsigned TICK_DIV = pwm_servo_pkg::DEF_TICK_DIV
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tick_st_t;

    tick_st_t s_d, s_q;

    assign tick_o = (s_q.cnt == TW'(TICK_DIV - 1));

    always_comb begin
        s_d = s_q;
        if (tick_o) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr #(
    parameter int unsigned PERIOD = pwm_servo_pkg::DEF_PERIOD,
    localparam int unsigned PW    = $clog2(PERIOD)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    output logic [PW-1:0] phase_o,
    output logic          wrap_o
);
    typedef struct packed {
        logic [PW-1:0] phase;
    } phase_st_t;

    phase_st_t s_d, s_q;

    assign phase_o = s_q.phase;
    assign wrap_o  = tick_i && (s_q.phase == PW'(PERIOD - 1));

    always_comb begin
        s_d = s_q;
        if (wrap_o) begin
            s_d.phase = '0;
        end else if (tick_i) begin
            s_d.phase = s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: a wrap always restarts the period at phase zero
    p_wrap_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (s_q.phase == '0));

endmodule

// File: rtl/pwm_upd_div.sv
module pwm_upd_div #(
    parameter int unsigned UPD_DIV = pwm_servo_pkg::DEF_UPD_DIV
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wrap_i,
    input  logic freeze_i,
    output logic stb_o
);
    localparam int unsigned UW = (UPD_DIV > 1) ? $clog2(UPD_DIV) : 1;

    typedef struct packed {
        logic [UW-1:0] cnt;
        logic          stb;
    } upd_st_t;

    upd_st_t s_d, s_q;

    assign stb_o = s_q.stb;

    always_comb begin
        s_d     = s_q;
        s_d.stb = 1'b0;
        if (freeze_i) begin
            s_d.cnt = '0;
        end else if (wrap_i) begin
            if (s_q.cnt == UW'(UPD_DIV - 1)) begin
                s_d.cnt = '0;
                s_d.stb = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: a frozen divider issues no strobe on the next clock
    p_no_stb_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_i |=> !s_q.stb);

    // R3: the strobe lasts one clock only
    p_stb_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.stb |=> !s_q.stb);

endmodule

// File: rtl/pwm_servo_engine.sv
module pwm_servo_engine #(
    parameter int unsigned TICK_DIV = pwm_servo_pkg::DEF_TICK_DIV,
    parameter int unsigned PERIOD   = pwm_servo_pkg::DEF_PERIOD,
    parameter int unsigned UPD_DIV  = pwm_servo_pkg::DEF_UPD_DIV
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic upd_en_i,
    input  logic dir_hi_i,
    input  logic freeze_i,
    output logic pwm_o,
    output logic pwm_n_o,
    output logic upd_stb_o
);
    import pwm_servo_pkg::*;

    localparam int unsigned PW = $clog2(PERIOD);
    localparam logic [PW-1:0] DUTY_MIN = PW'(1);
    localparam logic [PW-1:0] DUTY_MAX = PW'(PERIOD - 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [PW-1:0] duty;
        logic [PW-1:0] act;
    } eng_st_t;

    eng_st_t       s_d, s_q;
    logic          tick;
    logic          wrap;
    logic          stb;
    logic [PW-1:0] phase;
    step_dir_e     step_dir;

    pwm_tick_div #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    pwm_phase_ctr #(.PERIOD(PERIOD)) u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .phase_o (phase),
        .wrap_o  (wrap)
    );

    pwm_upd_div #(.UPD_DIV(UPD_DIV)) u_upd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wrap_i   (wrap),
        .freeze_i (freeze_i),
        .stb_o    (stb)
    );

    assign step_dir = step_dir_e'(s_q.sync[1]);

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], dir_hi_i};
        if (stb && upd_en_i && !freeze_i) begin
            if (step_dir == STEP_DOWN) begin
                if (s_q.duty > DUTY_MIN) begin
                    s_d.duty = s_q.duty - 1'b1;
                end
            end else begin
                if (s_q.duty < DUTY_MAX) begin
                    s_d.duty = s_q.duty + 1'b1;
                end
            end
        end
        if (wrap) begin
            s_d.act = s_q.duty;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.sync <= '0;
            s_q.duty <= DUTY_MAX;
            s_q.act  <= DUTY_MAX;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm_o     = (phase < s_q.act);
    assign pwm_n_o   = ~pwm_o;
    assign upd_stb_o = stb;

    // R9: the active duty only changes at a period wrap
    p_act_at_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> $stable(s_q.act));

    // R3: strobes sit in the first tick of a period
    p_stb_at_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb |-> (phase == '0));

    // R4: an enabled downward step lowers the duty by exactly one
    p_step_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb && upd_en_i && !freeze_i && s_q.sync[1] && (s_q.duty > DUTY_MIN))
        |=> (s_q.duty == $past(s_q.duty) - 1'b1));

    // R5: without an enabled strobe the duty register holds
    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stb || !upd_en_i || freeze_i) |=> $stable(s_q.duty));

    // R8: the floor and ceiling are never crossed
    p_floor_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((s_q.duty == DUTY_MIN) && s_q.sync[1]) |=> (s_q.duty >= DUTY_MIN));
    p_ceiling_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((s_q.duty == DUTY_MAX) && !s_q.sync[1]) |=> (s_q.duty == DUTY_MAX));

endmodule

// File: tb/pwm_servo_engine_tb_top.sv
module pwm_servo_engine_tb_top;

    localparam int TD  = 2;
    localparam int PER = 8;
    localparam int UD  = 3;
    localparam int PCLK = PER * TD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_en = 1'b0;
    logic dir_hi = 1'b0;
    logic freeze = 1'b0;
    logic pwm, pwm_n, upd_stb;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit mon_on  = 0;

    always #4 clk = ~clk;

    pwm_servo_engine #(.TICK_DIV(TD), .PERIOD(PER), .UPD_DIV(UD)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .upd_en_i  (upd_en),
        .dir_hi_i  (dir_hi),
        .freeze_i  (freeze),
        .pwm_o     (pwm),
        .pwm_n_o   (pwm_n),
        .upd_stb_o (upd_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int step_model(input int duty, input bit down);
        if (down) return (duty > 1) ? duty - 1 : duty;
        return (duty < PER - 1) ? duty + 1 : duty;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Reference model and monitor, sampled on the falling edge
    bit    prev_pwm = 0;
    bit    first = 1;
    bit    have_per = 0;
    bit    pend = 0;
    bit    exp_stb;
    bit    dh1 = 0, dh2 = 0;
    int    duty_m = PER - 1;
    int    exp_act = PER - 1;
    int    ucnt_m = 0;
    int    hcnt = 0, plen = 0;
    string last_tag = "R9";
    string per_tag  = "R1";

    always @(negedge clk) begin
        if (mon_on && !done) begin
            bit rise;
            rise = pwm && !prev_pwm;
            if (pend) begin
                int nd;
                nd = duty_m;
                if (!freeze && upd_en) nd = step_model(duty_m, dh2);
                if (freeze)       last_tag = "R6";
                else if (!upd_en) last_tag = "R5";
                else if (nd == duty_m) last_tag = "R8";
                else              last_tag = "R4";
                duty_m = nd;
                pend = 0;
            end
            exp_stb = 0;
            if (rise) begin
                if (have_per) begin
                    chk(hcnt == exp_act * TD, per_tag, hcnt, exp_act * TD);
                    chk(plen == PCLK, "R2", plen, PCLK);
                end
                chk(pwm_n == ~pwm, "R7", pwm_n, ~pwm);
                per_tag = (first) ? "R1" : last_tag;
                exp_act = duty_m;
                hcnt = 0;
                plen = 0;
                have_per = 1;
                if (first) begin
                    first = 0;
                end else if (freeze) begin
                    ucnt_m = 0;
                end else begin
                    exp_stb = (ucnt_m == UD - 1);
                    ucnt_m = exp_stb ? 0 : ucnt_m + 1;
                end
            end else if (freeze) begin
                ucnt_m = 0;
            end
            if (rise || upd_stb) begin
                chk(upd_stb == exp_stb, freeze ? "R6" : "R3", upd_stb, exp_stb);
            end
            pend = exp_stb;
            hcnt += pwm ? 1 : 0;
            plen++;
            prev_pwm = pwm;
            dh2 = dh1;
            dh1 = dir_hi;
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            chk(0, "R2 watchdog", cyc, 150000);
            finish_run();
        end
    end

    task automatic drive(input bit d, input bit en, input bit fz, input int ncyc);
        @(negedge clk);
        #1;
        dir_hi = d;
        upd_en = en;
        freeze = fz;
        repeat (ncyc) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(pwm == 1'b1, "R1", pwm, 1);
        chk(upd_stb == 1'b0, "R1", upd_stb, 0);
        chk(pwm_n == 1'b0, "R7", pwm_n, 0);
        @(posedge clk);
        #1;
        rst_n  = 1'b1;
        mon_on = 1;
        // updates disabled: duty must stay at full (R5)
        drive(1'b1, 1'b0, 1'b0, 200);
        // step down to the floor (R4, R8)
        drive(1'b1, 1'b1, 1'b0, 500);
        // step up to the ceiling (R4, R8)
        drive(1'b0, 1'b1, 1'b0, 500);
        // freeze then release (R6)
        drive(1'b1, 1'b1, 1'b1, 200);
        drive(1'b1, 1'b1, 1'b0, 200);
        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            bit d, en, fz;
            int n;
            d  = ($urandom % 10) < 6;
            en = ($urandom % 4) != 0;
            fz = ($urandom % 8) == 0;
            n  = 10 + ($urandom % 60);
            drive(d, en, fz, n);
        end
        drive(1'b0, 1'b0, 1'b0, 3 * PCLK);
        finish_run();
    end

endmodule